// File: doc/BRIEF.md
# Multi-Cycle 8-bit Register-Machine Processor Core

This core executes a compact 16-opcode instruction set. It uses an 8-bit datapath, eight general registers and a 16-bit address space. Every instruction is one 16-bit word. The core fetches it as two bytes, most significant byte first, over a single byte-wide synchronous memory port. That same port also serves data loads, data stores and the memory stack. A read issued in one cycle returns its byte in the next cycle. The core never encodes a memory or jump address in the instruction itself. It always forms the address at run time from two 8-bit registers, and the register named first gives the upper byte.

An instruction takes at least four cycles. Two cycles fetch the bytes, one cycle latches the word and one cycle executes it. A memory load or a pop takes one or two more cycles. The halt opcode sets the kill bit of the flag register. After that the core makes no further memory access until synchronous reset. Debug outputs always show the register file, program counter, stack pointer and flags.

Top module: `byte_cpu_core`

## Requirements
- R1: While reset is held and on the first cycle after it, PC reads 0x0000, SP reads 0xFFFF, all registers and flags read zero, and `halted` reads 0.
- R2: Instruction bytes are fetched from PC (upper byte, bits 15:8) and PC+1 (lower byte). PC advances by 2. Bits 15:12 select the opcode: ldr=0, ldi=1, ldm=2, st=3, push=4, pop=5, add=6, sub=7, mul=8, div=9, jp=10, jz=11, and=12, or=13, xor=14, done=15.
- R3: The fields at bits 11:8, 7:4 and 3:0 name registers A, B and C. Only the low three bits of each field select the register, and bit 3 of each field is ignored. ldi places its 8-bit immediate in bits 7:0.
- R4: ldr copies register B into A. ldi writes its immediate into A.
- R5: ldm reads memory at {B,C} into A. st writes register C to memory at {A,B}. The first-named register is always the upper address byte.
- R6: push writes register A at SP and then decrements SP. pop increments SP and then reads the byte at SP into A.
- R7: add, sub, and, or and xor write A = B op C modulo 256. mul writes the low 8 bits of B*C.
- R8: div writes the unsigned quotient B/C. If C is zero it writes 0xFF and leaves the zero flag unchanged.
- R9: Flag bit 0 (zero) is set when the value written by ldr, ldi, ldm, pop or an ALU op is zero, and cleared when that value is nonzero. Other instructions leave it unchanged.
- R10: jp sets PC to {A,B}. jz does the same only when the zero flag is set, and otherwise falls through to the next instruction.
- R11: done sets flag bit 7 and raises `halted`. From then on no memory read or write occurs and PC stays frozen until reset.
- R12: The memory port never asserts read and write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | 16 | Byte address for the current access |
| mem_rd | output | 1 | Read request; data returned on `mem_rdata` the next cycle |
| mem_we | output | 1 | Write strobe for `mem_wdata` at `mem_addr` |
| mem_wdata | output | 8 | Store data |
| mem_rdata | input | 8 | Read data, one cycle after `mem_rd` |
| halted | output | 1 | High once done has executed |
| dbg_regs | output | 64 | Register file, register n at bits [8n+7:8n] |
| dbg_pc | output | 16 | Program counter |
| dbg_sp | output | 16 | Stack pointer |
| dbg_flags | output | 8 | Flags: bit 0 zero, bit 7 kill |

## Verification
The zero flag carried across a division by zero is the hardest case to reach from the ports. No output shows it until a later conditional jump consumes it. The stimulus handles this in two steps. It first clears the flag with a nonzero load and then sets it with a zero load. Next it divides by the zero register, and only then does it issue jz. Ending at the jump target, rather than at the fall-through halt, shows that the flag survived. A countdown loop exercises taken and not-taken jz against a jp back-edge, and pushes and pops are interleaved so the stack-pointer order appears in the write stream.

// File: rtl/bcpu_pkg.sv
package bcpu_pkg;

  typedef enum logic [3:0] {
    OP_LDR  = 4'd0,
    OP_LDI  = 4'd1,
    OP_LDM  = 4'd2,
    OP_ST   = 4'd3,
    OP_PUSH = 4'd4,
    OP_POP  = 4'd5,
    OP_ADD  = 4'd6,
    OP_SUB  = 4'd7,
    OP_MUL  = 4'd8,
    OP_DIV  = 4'd9,
    OP_JP   = 4'd10,
    OP_JZ   = 4'd11,
    OP_AND  = 4'd12,
    OP_OR   = 4'd13,
    OP_XOR  = 4'd14,
    OP_DONE = 4'd15
  } op_e;

  typedef enum logic [2:0] {
    ST_FETCH_A,
    ST_FETCH_B,
    ST_LATCH,
    ST_EXEC,
    ST_POP_RD,
    ST_LOAD,
    ST_HALT
  } state_e;

  localparam int FIELD_W  = 4;
  localparam int ZERO_BIT = 0;
  localparam int KILL_BIT = 7;

endpackage

// File: rtl/bcpu_alu.sv
module bcpu_alu
  import bcpu_pkg::*;
#(
  parameter int DW = 8
) (
  input  op_e           op,
  input  logic [DW-1:0] lhs,
  input  logic [DW-1:0] rhs,
  output logic [DW-1:0] res,
  output logic          zf_upd
);

  logic [2*DW-1:0] prod;
  assign prod = lhs * rhs;

  always_comb begin
    res    = '0;
    zf_upd = 1'b1;
    case (op)
      OP_ADD: res = lhs + rhs;
      OP_SUB: res = lhs - rhs;
      OP_MUL: res = prod[DW-1:0];
      OP_DIV: begin
        if (rhs == '0) begin
          res    = '1;
          zf_upd = 1'b0;
        end else begin
          res = lhs / rhs;
        end
      end
      OP_AND: res = lhs & rhs;
      OP_OR:  res = lhs | rhs;
      OP_XOR: res = lhs ^ rhs;
      default: zf_upd = 1'b0;
    endcase
  end

endmodule

// File: rtl/bcpu_regfile.sv
module bcpu_regfile #(
  parameter  int DW   = 8,
  parameter  int NREG = 8,
  localparam int RAW  = $clog2(NREG)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               we,
  input  logic [RAW-1:0]     waddr,
  input  logic [DW-1:0]      wdata,
  input  logic [RAW-1:0]     ra_a,
  input  logic [RAW-1:0]     ra_b,
  input  logic [RAW-1:0]     ra_c,
  output logic [DW-1:0]      rd_a,
  output logic [DW-1:0]      rd_b,
  output logic [DW-1:0]      rd_c,
  output logic [NREG*DW-1:0] dbg_flat
);

  logic [DW-1:0] regs [NREG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (we) begin
      regs[waddr] <= wdata;
    end
  end

  assign rd_a = regs[ra_a];
  assign rd_b = regs[ra_b];
  assign rd_c = regs[ra_c];

  for (genvar g = 0; g < NREG; g++) begin : g_dbg
    assign dbg_flat[g*DW +: DW] = regs[g];
  end

  // R4: a write lands in the addressed register on the next cycle
  p_write_lands_r4: assert property (@(posedge clk) disable iff (rst)
    we |=> regs[$past(waddr)] == $past(wdata));

endmodule

// File: rtl/byte_cpu_core.sv
module byte_cpu_core
  import bcpu_pkg::*;
#(
  parameter  int DW       = 8,
  parameter  int NREG     = 8,
  localparam int AW       = 2 * DW,
  localparam int RAW      = $clog2(NREG)
) (
  input  logic               clk,
  input  logic               rst,
  output logic [AW-1:0]      mem_addr,
  output logic               mem_rd,
  output logic               mem_we,
  output logic [DW-1:0]      mem_wdata,
  input  logic [DW-1:0]      mem_rdata,
  output logic               halted,
  output logic [NREG*DW-1:0] dbg_regs,
  output logic [AW-1:0]      dbg_pc,
  output logic [AW-1:0]      dbg_sp,
  output logic [DW-1:0]      dbg_flags
);

  localparam int IW = 2 * DW;

  state_e        st;
  logic [AW-1:0] pc, sp;
  logic [DW-1:0] flags;
  logic [DW-1:0] ir_hi;
  logic [IW-1:0] ir;
  logic          halted_q;

  op_e            op;
  logic [RAW-1:0] fa, fb, fc;
  logic [DW-1:0]  imm;
  logic [DW-1:0]  rd_a, rd_b, rd_c;
  logic [DW-1:0]  alu_res;
  logic           alu_zf;
  logic           is_alu;
  logic           rf_we;
  logic [DW-1:0]  rf_wdata;
  logic [AW-1:0]  jump_tgt;
  logic           zf_load;

  assign op  = op_e'(ir[IW-1 -: FIELD_W]);
  assign fa  = ir[2*FIELD_W +: RAW];
  assign fb  = ir[FIELD_W +: RAW];
  assign fc  = ir[0 +: RAW];
  assign imm = ir[DW-1:0];

  assign is_alu = (op == OP_ADD) || (op == OP_SUB) || (op == OP_MUL) ||
                  (op == OP_DIV) || (op == OP_AND) || (op == OP_OR)  ||
                  (op == OP_XOR);

  assign jump_tgt = {rd_a, rd_b};

  bcpu_regfile #(.DW(DW), .NREG(NREG)) u_rf (
    .clk      (clk),
    .rst      (rst),
    .we       (rf_we),
    .waddr    (fa),
    .wdata    (rf_wdata),
    .ra_a     (fa),
    .ra_b     (fb),
    .ra_c     (fc),
    .rd_a     (rd_a),
    .rd_b     (rd_b),
    .rd_c     (rd_c),
    .dbg_flat (dbg_regs)
  );

  bcpu_alu #(.DW(DW)) u_alu (
    .op     (op),
    .lhs    (rd_b),
    .rhs    (rd_c),
    .res    (alu_res),
    .zf_upd (alu_zf)
  );

  // register write port
  always_comb begin
    rf_we    = 1'b0;
    rf_wdata = alu_res;
    zf_load  = 1'b0;
    if (st == ST_LOAD) begin
      rf_we    = 1'b1;
      rf_wdata = mem_rdata;
      zf_load  = 1'b1;
    end else if (st == ST_EXEC) begin
      case (op)
        OP_LDR: begin rf_we = 1'b1; rf_wdata = rd_b; zf_load = 1'b1; end
        OP_LDI: begin rf_we = 1'b1; rf_wdata = imm;  zf_load = 1'b1; end
        default: begin
          rf_we   = is_alu;
          zf_load = is_alu && alu_zf;
        end
      endcase
    end
  end

  // memory port
  always_comb begin
    mem_addr  = pc;
    mem_rd    = 1'b0;
    mem_we    = 1'b0;
    mem_wdata = rd_c;
    case (st)
      ST_FETCH_A: mem_rd = 1'b1;
      ST_FETCH_B: begin
        mem_addr = pc + AW'(1);
        mem_rd   = 1'b1;
      end
      ST_EXEC: begin
        case (op)
          OP_LDM: begin
            mem_addr = {rd_b, rd_c};
            mem_rd   = 1'b1;
          end
          OP_ST: begin
            mem_addr  = {rd_a, rd_b};
            mem_we    = 1'b1;
            mem_wdata = rd_c;
          end
          OP_PUSH: begin
            mem_addr  = sp;
            mem_we    = 1'b1;
            mem_wdata = rd_a;
          end
          default: ;
        endcase
      end
      ST_POP_RD: begin
        mem_addr = sp;
        mem_rd   = 1'b1;
      end
      default: ;
    endcase
  end

  // sequencer
  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_FETCH_A;
      pc       <= '0;
      sp       <= '1;
      flags    <= '0;
      ir_hi    <= '0;
      ir       <= '0;
      halted_q <= 1'b0;
    end else begin
      if (zf_load) flags[ZERO_BIT] <= (rf_wdata == '0);
      case (st)
        ST_FETCH_A: st <= ST_FETCH_B;
        ST_FETCH_B: begin
          ir_hi <= mem_rdata;
          st    <= ST_LATCH;
        end
        ST_LATCH: begin
          ir <= {ir_hi, mem_rdata};
          pc <= pc + AW'(2);
          st <= ST_EXEC;
        end
        ST_EXEC: begin
          st <= ST_FETCH_A;
          case (op)
            OP_LDM:  st <= ST_LOAD;
            OP_PUSH: sp <= sp - AW'(1);
            OP_POP: begin
              sp <= sp + AW'(1);
              st <= ST_POP_RD;
            end
            OP_JP:   pc <= jump_tgt;
            OP_JZ:   if (flags[ZERO_BIT]) pc <= jump_tgt;
            OP_DONE: begin
              flags[KILL_BIT] <= 1'b1;
              halted_q        <= 1'b1;
              st              <= ST_HALT;
            end
            default: ;
          endcase
        end
        ST_POP_RD: st <= ST_LOAD;
        ST_LOAD:   st <= ST_FETCH_A;
        default:   st <= ST_HALT;
      endcase
    end
  end

  assign halted    = halted_q;
  assign dbg_pc    = pc;
  assign dbg_sp    = sp;
  assign dbg_flags = flags;

  // R12: one access kind per cycle
  p_rd_we_excl_r12: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && mem_we));

  // R11: a halted core stays halted, quiet and frozen
  p_halt_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    halted |-> (!mem_rd && !mem_we));
  p_halt_hold_r11: assert property (@(posedge clk) disable iff (rst)
    halted |=> (halted && $stable(dbg_pc)));

  // R2: latching a fetched word advances PC by two
  p_pc_step_r2: assert property (@(posedge clk) disable iff (rst)
    (st == ST_LATCH) |=> (dbg_pc == $past(dbg_pc) + AW'(2)));

  // R6: push writes at the old SP, then SP has moved down by one
  p_push_order_r6: assert property (@(posedge clk) disable iff (rst)
    (st == ST_EXEC && op == OP_PUSH) |-> (mem_we && mem_addr == dbg_sp));
  p_push_dec_r6: assert property (@(posedge clk) disable iff (rst)
    (st == ST_EXEC && op == OP_PUSH) |=> (dbg_sp == $past(dbg_sp) - AW'(1)));

  // R8: a zero divisor produces all ones and keeps the zero flag
  p_div_zero_r8: assert property (@(posedge clk) disable iff (rst)
    (st == ST_EXEC && op == OP_DIV && rd_c == '0) |=>
      (dbg_flags[ZERO_BIT] == $past(dbg_flags[ZERO_BIT])));

endmodule

// File: tb/test_byte_cpu_core.sv
module test_byte_cpu_core;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] mem_addr;
  logic        mem_rd, mem_we;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata = 8'h00;
  logic        halted;
  logic [63:0] dbg_regs;
  logic [15:0] dbg_pc, dbg_sp;
  logic [7:0]  dbg_flags;

  byte_cpu_core i_byte_cpu_core (
    .clk       (clk),
    .rst       (rst),
    .mem_addr  (mem_addr),
    .mem_rd    (mem_rd),
    .mem_we    (mem_we),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata),
    .halted    (halted),
    .dbg_regs  (dbg_regs),
    .dbg_pc    (dbg_pc),
    .dbg_sp    (dbg_sp),
    .dbg_flags (dbg_flags)
  );

  always #2 clk = ~clk;

  int n_cmp = 0;
  int n_bad = 0;
  int quiet_acc = 0;
  int pa = 0;

  // memory model: synchronous, one-cycle read latency
  logic [7:0] mem [int];

  always @(posedge clk) begin
    if (mem_rd) mem_rdata <= mem.exists(int'(mem_addr)) ? mem[int'(mem_addr)] : 8'h00;
    if (mem_we) mem[int'(mem_addr)] = mem_wdata;
    if (!rst && halted && (mem_rd || mem_we)) quiet_acc++;
  end

  // scoreboard queues
  typedef struct {
    logic [15:0] addr;
    logic [7:0]  data;
    string       req;
  } wr_item_t;

  typedef struct {
    int          kind;   // 0 reg, 1 pc, 2 sp, 3 flags
    int          idx;
    logic [15:0] val;
    string       req;
  } st_item_t;

  wr_item_t wr_q[$];
  st_item_t st_q[$];

  task automatic exp_wr(input logic [15:0] a, input logic [7:0] d, input string req);
    wr_item_t e;
    e.addr = a; e.data = d; e.req = req;
    wr_q.push_back(e);
  endtask

  task automatic exp_st(input int kind, input int idx, input logic [15:0] v, input string req);
    st_item_t e;
    e.kind = kind; e.idx = idx; e.val = v; e.req = req;
    st_q.push_back(e);
  endtask

  task automatic exp_regs(input logic [7:0] r [8], input string req);
    for (int i = 0; i < 8; i++) exp_st(0, i, {8'h00, r[i]}, req);
  endtask

  // write monitor
  always @(negedge clk) begin
    if (!rst && mem_we) begin
      n_cmp++;
      if (wr_q.size() == 0) begin
        n_bad++;
        $display("FAIL R5/R6 unexpected write: actual addr=%h data=%h expected none",
                 mem_addr, mem_wdata);
      end else begin
        wr_item_t e;
        e = wr_q.pop_front();
        if (e.addr !== mem_addr || e.data !== mem_wdata) begin
          n_bad++;
          $display("FAIL %s write: actual addr=%h data=%h expected addr=%h data=%h",
                   e.req, mem_addr, mem_wdata, e.addr, e.data);
        end
      end
    end
  end

  task automatic check(input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic drain_state();
    while (st_q.size() != 0) begin
      st_item_t e;
      logic [15:0] act;
      e = st_q.pop_front();
      case (e.kind)
        0:       act = {8'h00, dbg_regs[e.idx*8 +: 8]};
        1:       act = dbg_pc;
        2:       act = dbg_sp;
        default: act = {8'h00, dbg_flags};
      endcase
      check(e.req, $sformatf("state kind%0d idx%0d", e.kind, e.idx), act, e.val);
    end
  endtask

  task automatic emit(input logic [15:0] w);
    mem[pa]     = w[15:8];
    mem[pa + 1] = w[7:0];
    pa += 2;
  endtask

  task automatic run_prog(input int limit);
    int cyc;
    logic [15:0] pc_h;
    rst = 1'b1;
    repeat (2) @(negedge clk);
    // R1: reset state
    check("R1", "pc", dbg_pc, 16'h0000);
    check("R1", "sp", dbg_sp, 16'hFFFF);
    check("R1", "flags", {8'h00, dbg_flags}, 16'h0000);
    check("R1", "halted", {15'h0, halted}, 16'h0000);
    check("R1", "regs nonzero", {15'h0, (dbg_regs != 64'h0)}, 16'h0000);
    rst = 1'b0;
    cyc = 0;
    while (!halted && cyc < limit) begin
      @(negedge clk);
      cyc++;
    end
    n_cmp++;
    if (!halted) begin
      n_bad++;
      $display("FAIL R11 watchdog: actual halted=0 expected halted=1");
    end
    // R11: quiet and frozen after halt
    pc_h = dbg_pc;
    quiet_acc = 0;
    repeat (12) @(negedge clk);
    check("R11", "accesses after halt", 16'(quiet_acc), 16'h0000);
    check("R11", "pc frozen", dbg_pc, pc_h);
    check("R11", "halted", {15'h0, halted}, 16'h0001);
    check("R5", "pending writes", 16'(wr_q.size()), 16'h0000);
    wr_q.delete();
    drain_state();
  endtask

  initial begin
    #(4 * 200000);
    n_bad++;
    $display("FAIL global watchdog: actual=running expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] r [8];

    // ---- program 1: ALU ops and ignored field bit (R2 R3 R4 R7 R8 R9) ----
    mem.delete(); pa = 0;
    emit(16'h11C8);  // ldi r1,200
    emit(16'h1264);  // ldi r2,100
    emit(16'h6312);  // add r3  -> 0x2C  R7
    emit(16'h7421);  // sub r4  -> 0x9C  R7
    emit(16'h8512);  // mul r5  -> 0x20  R7
    emit(16'h9612);  // div r6  -> 0x02  R8
    emit(16'hC712);  // and r7  -> 0x40
    emit(16'hD012);  // or  r0  -> 0xEC
    emit(16'hEF9A);  // xor with field bit 3 set: r7 = r1^r2 = 0xAC  R3
    emit(16'hF000);  // done
    r = '{8'hEC, 8'hC8, 8'h64, 8'h2C, 8'h9C, 8'h20, 8'h02, 8'hAC};
    exp_regs(r, "R7");
    exp_st(1, 0, 16'h0014, "R2");
    exp_st(2, 0, 16'hFFFF, "R6");
    exp_st(3, 0, 16'h0080, "R9");
    run_prog(2000);

    // ---- program 2: memory, stack, div-by-zero flag, jz taken (R5 R6 R8 R9 R10) ----
    mem.delete(); pa = 0;
    emit(16'h11BE);  // ldi r1,BE
    emit(16'h12EF);  // ldi r2,EF
    emit(16'h132A);  // ldi r3,2A
    emit(16'h3123);  // st  [r1:r2] <- r3
    emit(16'h2412);  // ldm r4 <- [r1:r2]
    emit(16'h4400);  // push r4
    emit(16'h1507);  // ldi r5,7
    emit(16'h4500);  // push r5
    emit(16'h5600);  // pop r6
    emit(16'h5700);  // pop r7
    emit(16'h1100);  // ldi r1,0
    emit(16'h1230);  // ldi r2,0x30 (clears zero)
    emit(16'h1000);  // ldi r0,0 (sets zero)
    emit(16'h9050);  // div r0,r5,r0 -> FF, zero kept  R8
    emit(16'hB120);  // jz [r1:r2] = 0x0030  R10
    emit(16'hF000);  // fall-through halt
    pa = 16'h30;
    emit(16'h1355);  // ldi r3,55
    emit(16'hF000);  // done
    exp_wr(16'hBEEF, 8'h2A, "R5");
    exp_wr(16'hFFFF, 8'h2A, "R6");
    exp_wr(16'hFFFE, 8'h07, "R6");
    r = '{8'hFF, 8'h00, 8'h30, 8'h55, 8'h2A, 8'h07, 8'h07, 8'h2A};
    exp_regs(r, "R5 R6 R8 R10");
    exp_st(1, 0, 16'h0034, "R10");
    exp_st(2, 0, 16'hFFFF, "R6");
    exp_st(3, 0, 16'h0080, "R9");
    run_prog(2000);

    // ---- program 3: countdown loop, jz not taken, ldr (R4 R9 R10) ----
    mem.delete(); pa = 0;
    emit(16'h1103);  // ldi r1,3
    emit(16'h1201);  // ldi r2,1
    emit(16'h1600);  // ldi r6,0
    emit(16'h170A);  // ldi r7,0x0A (loop)
    emit(16'h151A);  // ldi r5,0x1A (exit)
    emit(16'h6332);  // 10: add r3,r3,r2
    emit(16'h7112);  // 12: sub r1,r1,r2
    emit(16'hB650);  // 14: jz exit
    emit(16'hA670);  // 16: jp loop
    emit(16'hF000);  // 18: unreached
    pa = 16'h1A;
    emit(16'h0030);  // ldr r0,r3 -> 3, zero clear  R4
    emit(16'hB670);  // jz not taken  R10
    emit(16'h0410);  // ldr r4,r1 -> 0, zero set  R9
    emit(16'hF000);  // done
    r = '{8'h03, 8'h00, 8'h01, 8'h03, 8'h00, 8'h1A, 8'h00, 8'h0A};
    exp_regs(r, "R4 R10");
    exp_st(1, 0, 16'h0022, "R10");
    exp_st(2, 0, 16'hFFFF, "R6");
    exp_st(3, 0, 16'h0081, "R9");
    run_prog(4000);

    // final reset check
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check("R1", "pc after reset", dbg_pc, 16'h0000);
    check("R1", "regs after reset", {15'h0, (dbg_regs != 64'h0)}, 16'h0000);
    check("R1", "flags after reset", {8'h00, dbg_flags}, 16'h0000);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule